// File: doc/BRIEF.md
# Oversize PRG Address Composer

This block forms the upper physical PRG-ROM address (A24 down to A13) for every CPU access to the $8000-$FFFF program window of an oversize MMC3-style banking controller. It merges the 8-bit inner bank number chosen by the MMC3 core with three outer configuration bytes: an offset/mask byte, a second mask/offset byte that also holds the GNROM size flag, and a mode byte. The result lets one large ROM hold many independent images.

There are three addressing modes. In plain oversize mode the MMC3 bank drives A16..A13. GNROM mode drives those low bits from outer fields and the CPU address instead, giving 16 KiB or 32 KiB flat banks. Weird mode substitutes bank 0 for the two top windows. In every mode, each bit from A17 to A20 has its own mask. The mask picks between the MMC3 bank bit and an outer offset bit. A21 and above always come from the outer offset.

The block is purely combinational. It is placed between the MMC3 bank selection logic and the ROM address pins.

Top module: `prg_oversize_composer`

## Requirements
- R1: Output bits A24, A23, A22 and A21 always equal outer0 bit 5, outer0 bit 4, outer1 bit 3 and outer1 bit 2, respectively.
- R2: A17 comes from outer0 bit 0 when outer0 bit 6 is 1, and from MMC3 bank bit 4 when it is 0.
- R3: A18 comes from outer0 bit 1 when outer1 bit 7 is 1, and from MMC3 bank bit 5 when it is 0.
- R4: A19 comes from MMC3 bank bit 6 when outer1 bit 6 is 1, and from outer0 bit 2 when it is 0. A20 comes from MMC3 bank bit 7 when outer1 bit 5 is 1, and from outer1 bit 4 when it is 0.
- R5: When outer3 bit 4 is 0 (MMC3 mode), A16..A13 equal MMC3 bank bits 3..0, except in the case described in R7.
- R6: When outer3 bit 4 is 1 (GNROM mode), A16..A15 equal outer3 bits 3..2 and A13 equals CPU A13. A14 equals CPU A14 when outer1 bit 1 is 1 (32 KiB banks), and equals outer3 bit 1 when it is 0 (16 KiB banks).
- R7: When outer3 bit 6 is 1 (weird mode), the bank-mode input is 0 and CPU A14 is 1 (windows $C000 and $E000), the MMC3 bank is replaced by 0 before masking. With bank-mode 1, no replacement happens.
- R8: The masks of R2 to R4 stay in effect in GNROM mode. This includes the weird-mode bank replacement when both modes are set.
- R9: The output depends on its inputs only, with no storage. Outer bits not named above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| mmc_bank | input | 8 | 8 KiB bank number from the MMC3 core for this access |
| mmc_prg_mode | input | 1 | MMC3 PRG bank order: 0 normal, 1 inverted |
| outer0 | input | 8 | Outer byte 0: offsets A17..A19 and A23..A24, A17 mask |
| outer1 | input | 8 | Outer byte 1: A18..A20 masks, offsets A20..A22, GNROM size |
| outer3 | input | 8 | Outer byte 3: weird and GNROM mode, GNROM PRG offset |
| prg_addr | output | 12 | Physical PRG address bits A24..A13 |

## Verification
The hand-built vectors check each part separately. All-ones banks with zero masks show that the lower mask sense selects the MMC3 bank. The A19/A20 masks set with an alternating bank show that their sense is inverted. All offsets set with a zero bank show that the offset path works. GNROM vectors in 32 KiB and 16 KiB modes show which of CPU A14 and outer3 bit 1 drives A14. Weird-mode vectors at $8000 and $C000, and with the inverted bank order, separate the bank substitution from the normal pass-through. A long pseudo-random sweep compares every output bit with a model built from the requirements. A check that toggles the undefined outer bits confirms that they have no effect on the output.

// File: rtl/prg_oversize_composer.sv
module prg_oversize_composer #(
  parameter int BANK_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic              cpu_a14,
  input  logic              cpu_a13,
  input  logic [BANK_W-1:0] mmc_bank,
  input  logic              mmc_prg_mode,
  input  logic [7:0]        outer0,
  input  logic [7:0]        outer1,
  input  logic [7:0]        outer3,
  output logic [OUT_W-1:0]  prg_addr
);
  localparam int LOW_W = 4;

  logic gnrom, weird, size32, fix_zero;
  logic [BANK_W-1:0] bank;
  logic [LOW_W-1:0]  low;
  logic a17, a18, a19, a20;
  logic unused_bits;

  assign gnrom    = outer3[4];
  assign weird    = outer3[6];
  assign size32   = outer1[1];
  assign fix_zero = weird & ~mmc_prg_mode & cpu_a14;
  assign bank     = fix_zero ? '0 : mmc_bank;

  assign low = gnrom ? {outer3[3:2], (size32 ? cpu_a14 : outer3[1]), cpu_a13}
                     : bank[LOW_W-1:0];

  assign a17 = outer0[6] ? outer0[0] : bank[4];
  assign a18 = outer1[7] ? outer0[1] : bank[5];
  assign a19 = outer1[6] ? bank[6]   : outer0[2];
  assign a20 = outer1[5] ? bank[7]   : outer1[4];

  assign prg_addr = {outer0[5], outer0[4], outer1[3], outer1[2],
                     a20, a19, a18, a17, low};

  assign unused_bits = ^{outer0[7], outer0[3], outer1[0], outer3[7], outer3[5], outer3[0]};

  always_comb begin
    p_upper_offset_r1: assert (prg_addr[11:8] == {outer0[5:4], outer1[3:2]})
      else $error("upper offset bits mismatch");
    if (outer0[6])
      p_a17_offset_r2: assert (prg_addr[4] == outer0[0]) else $error("A17 offset");
    if (outer1[7])
      p_a18_offset_r3: assert (prg_addr[5] == outer0[1]) else $error("A18 offset");
    if (!outer1[6])
      p_a19_offset_r4: assert (prg_addr[6] == outer0[2]) else $error("A19 offset");
    if (!gnrom && !fix_zero)
      p_mmc3_low_r5: assert (prg_addr[3:0] == mmc_bank[3:0]) else $error("MMC3 low bits");
    if (gnrom)
      p_gnrom_a13_r6: assert (prg_addr[0] == cpu_a13 && prg_addr[3:2] == outer3[3:2])
        else $error("GNROM low bits");
    if (weird && !mmc_prg_mode && cpu_a14 && !gnrom)
      p_weird_zero_r7: assert (prg_addr[3:0] == 4'h0) else $error("weird fixed bank");
  end
endmodule

// File: tb/prg_oversize_composer_test.sv
module prg_oversize_composer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       a14, a13, mode;
  logic [7:0] bank, o0, o1, o3;
  logic [11:0] addr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  prg_oversize_composer uut (
    .cpu_a14(a14), .cpu_a13(a13), .mmc_bank(bank), .mmc_prg_mode(mode),
    .outer0(o0), .outer1(o1), .outer3(o3), .prg_addr(addr)
  );

  // {o0, o1, o3, bank, mode, a14, a13, expected}
  localparam int NV = 9;
  localparam logic [46:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 12'h03F},
    {8'h00, 8'h60, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b1, 12'h0A5},
    {8'h77, 8'h9C, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 12'hFF0},
    {8'h00, 8'h02, 8'h1C, 8'hFF, 1'b0, 1'b1, 1'b0, 12'h03E},
    {8'h04, 8'h00, 8'h1A, 8'h00, 1'b0, 1'b0, 1'b1, 12'h04B},
    {8'h00, 8'h60, 8'h40, 8'hFE, 1'b0, 1'b1, 1'b0, 12'h000},
    {8'h00, 8'h60, 8'h40, 8'hFE, 1'b0, 1'b0, 1'b0, 12'h0FE},
    {8'h00, 8'h60, 8'h40, 8'hFF, 1'b1, 1'b1, 1'b1, 12'h0FF},
    {8'h00, 8'h62, 8'h50, 8'hFF, 1'b0, 1'b1, 1'b1, 12'h003}
  };
  localparam string VTAG [NV] = '{"R2 R3", "R4", "R1", "R6 R8", "R6",
                                  "R7", "R7", "R7", "R8"};

  function automatic logic [11:0] model(input logic [7:0] r0, r1, r3, b,
                                        input logic m, c14, c13);
    logic [7:0] eb;
    logic [3:0] lo;
    eb = (r3[6] && !m && c14) ? 8'h00 : b;
    if (r3[4]) lo = {r3[3], r3[2], r1[1] ? c14 : r3[1], c13};
    else       lo = eb[3:0];
    return {r0[5], r0[4], r1[3], r1[2],
            r1[5] ? eb[7] : r1[4], r1[6] ? eb[6] : r0[2],
            r1[7] ? r0[1] : eb[5], r0[6] ? r0[0] : eb[4], lo};
  endfunction

  task automatic apply(input logic [7:0] r0, r1, r3, b, input logic m, c14, c13);
    @(posedge clk);
    o0 = r0; o1 = r1; o3 = r3; bank = b; mode = m; a14 = c14; a13 = c13;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] exp);
    tests++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s: prg_addr=%03h expected %03h", req, addr, exp);
    end
  endtask

  initial begin
    o0 = 0; o1 = 0; o3 = 0; bank = 0; mode = 0; a14 = 0; a13 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset-state zero inputs", 12'h000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][46:39], VEC[i][38:31], VEC[i][30:23], VEC[i][22:15],
            VEC[i][14], VEC[i][13], VEC[i][12]);
      check(VTAG[i], VEC[i][11:0]);
    end

    // R9: undefined outer bits toggled, output unchanged
    apply(8'h88, 8'h61, 8'hA1, 8'hA5, 1'b0, 1'b0, 1'b1);
    check("R9 ignored bits", 12'h0A5);
    // R7: inverted order, $C000 window keeps bank
    apply(8'h00, 8'h60, 8'h40, 8'h3C, 1'b1, 1'b1, 1'b0);
    check("R7 inverted order", 12'h03C);
    // R5: MMC3 mode ignores GNROM offsets and CPU A13
    apply(8'h00, 8'h00, 8'h0E, 8'h09, 1'b0, 1'b1, 1'b0);
    check("R5 mmc3 low", 12'h009);

    begin
      logic [31:0] lfsr = 32'hACE1_2468;
      logic [35:0] s;
      for (int k = 0; k < 3000; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        s[31:0] = lfsr;
        s[35:32] = lfsr[3:0] ^ lfsr[31:28];
        apply(s[7:0], s[15:8], s[23:16], s[31:24], s[32], s[33], s[34]);
        check("R1 R2 R3 R4 R5 R6 R7 R8 sweep",
              model(s[7:0], s[15:8], s[23:16], s[31:24], s[32], s[33], s[34]));
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule